// File: doc/BRIEF.md
# Serial-Clock Idle Sleep and Wake Controller

This block decides whether a converter core runs normally or sits in a low-power sleep state. It does this only by watching how long the shared serial clock line stays at one level. It samples that line on a free-running timebase. A long unbroken high level puts the core to sleep. A long enough unbroken low level wakes it again. The block uses no extra control pin for this. Normal mode is the state after power-up.

On wake the block sends the core a one-cycle reset, so all core logic, including the decimation filter, starts from a clean state. It also restarts a settling counter. The counter counts completed conversions and raises a result-valid flag from the fourth one onward, because the first three results after power-up or after a wake come from a filter that is still filling. While the block is asleep it also forces the serial data driver's output enable low.

Both thresholds are parameters counted in timebase ticks. The sleep threshold should be set to a time between the shortest and the longest allowed sleep-entry delay. The serial clock input is asynchronous, so it passes through a two-stage synchronizer before any counting.

Top module: `sclk_sleep_ctrl`

## Requirements
- R1: After reset, the outputs are: sleep 0, core_rst 0, settle_cnt 0 and result_valid 0.
- R2: In normal mode, the block enters sleep when the synchronized clock line has been high for SLEEP_TICKS consecutive timebase cycles. sleep reads 1 after SLEEP_TICKS+2 rising timebase edges, counted from the first edge that sees sclk_in high; one edge earlier it still reads 0.
- R3: In normal mode, any low sample restarts the high-time count. High runs shorter than SLEEP_TICKS, separated by short lows, never cause sleep.
- R4: In sleep, the block wakes when the line has been low for WAKE_TICKS consecutive cycles. sleep reads 0 after WAKE_TICKS+2 edges and still reads 1 one edge earlier. Any high sample restarts the low-time count.
- R5: core_rst is high for exactly one timebase cycle. That cycle is the first cycle in which sleep reads 0 after a wake, and core_rst is high at no other time.
- R6: In normal mode, each cycle with conv_done high adds one to settle_cnt. The count saturates at SETTLE_CONV (4 by default). result_valid is 1 exactly when settle_cnt equals SETTLE_CONV.
- R7: A wake clears settle_cnt to 0. conv_done pulses that arrive during sleep, or in the core_rst cycle, leave settle_cnt unchanged.
- R8: sdo_oe is 1 only when sdo_oe_req is 1, cs_n is 0 and sleep is 0.
- R9: cs_n has no effect on sleep entry, on wake, or on when they happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sclk_in | input | 1 | Serial clock line, asynchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| conv_done | input | 1 | One-cycle pulse from the core for each completed conversion |
| sdo_oe_req | input | 1 | Output enable requested by the core's serial data logic |
| sdo_oe | output | 1 | Gated output enable for the serial data driver |
| sleep | output | 1 | 1 while the core is in sleep |
| core_rst | output | 1 | One-cycle core reset issued on wake |
| settle_cnt | output | $clog2(SETTLE_CONV+1) | Number of conversions completed since the last reset or wake, saturating |
| result_valid | output | 1 | The filter has refilled and results can be used |

## Verification
The bench builds the block with SLEEP_TICKS=40 and WAKE_TICKS=6, and keeps SETTLE_CONV at 4. With these values, sleep entry and wake can each be reached by hundreds of random clock-line segments in a short run. The exact entry and wake edges can be probed one cycle before and one cycle at the threshold. Random segment lengths avoid the two lengths at each threshold where the decision falls after the segment ends, so every segment has a single predicted mode. The settling count is driven through saturation, through sleep, and through the wake cycle itself.

// File: rtl/sclk_sleep_ctrl.sv
module sclk_sleep_ctrl #(
  parameter int SLEEP_TICKS = 400,
  parameter int WAKE_TICKS  = 16,
  parameter int SETTLE_CONV = 4,
  localparam int RUN_MAX = (SLEEP_TICKS > WAKE_TICKS) ? SLEEP_TICKS : WAKE_TICKS,
  localparam int RW = $clog2(RUN_MAX + 1),
  localparam int SW = $clog2(SETTLE_CONV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          cs_n,
  input  logic          conv_done,
  input  logic          sdo_oe_req,
  output logic          sdo_oe,
  output logic          sleep,
  output logic          core_rst,
  output logic [SW-1:0] settle_cnt,
  output logic          result_valid
);

  logic [1:0]    sync_q;
  logic          sclk_s;
  logic [RW-1:0] run_cnt;
  logic          enter_now;
  logic          wake_now;

  assign sclk_s    = sync_q[1];
  assign enter_now = !sleep && sclk_s && (run_cnt == RW'(SLEEP_TICKS - 1));
  assign wake_now  = sleep && !sclk_s && (run_cnt == RW'(WAKE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], sclk_in};
  end

  // one counter measures the run of the level that matters in the current mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      sleep   <= 1'b0;
    end else if (enter_now) begin
      run_cnt <= '0;
      sleep   <= 1'b1;
    end else if (wake_now) begin
      run_cnt <= '0;
      sleep   <= 1'b0;
    end else if (sclk_s == sleep) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst <= 1'b0;
    else        core_rst <= wake_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settle_cnt <= '0;
    else if (wake_now)
      settle_cnt <= '0;
    else if (conv_done && !sleep && !core_rst && settle_cnt != SW'(SETTLE_CONV))
      settle_cnt <= settle_cnt + 1'b1;
  end

  assign result_valid = (settle_cnt == SW'(SETTLE_CONV));
  assign sdo_oe       = sdo_oe_req && !cs_n && !sleep;

endmodule

// File: rtl/sclk_sleep_ctrl_checker.sv
module sclk_sleep_ctrl_checker #(
  parameter int SETTLE_CONV = 4,
  localparam int SW = $clog2(SETTLE_CONV + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          core_rst,
  input logic          conv_done,
  input logic [SW-1:0] settle_cnt,
  input logic          sdo_oe
);

  a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);

  a_r5_rst_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> core_rst);

  a_r5_rst_only_wake: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> $fell(sleep));

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    settle_cnt <= SW'(SETTLE_CONV));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && !$stable(settle_cnt)) |-> (settle_cnt == $past(settle_cnt) + 1'b1 && $past(conv_done)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> settle_cnt == '0);

  a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $past(sleep)) |-> $stable(settle_cnt));

  a_r8_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !sdo_oe);

endmodule

bind sclk_sleep_ctrl sclk_sleep_ctrl_checker #(.SETTLE_CONV(SETTLE_CONV)) u_checker (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .core_rst(core_rst),
  .conv_done(conv_done), .settle_cnt(settle_cnt), .sdo_oe(sdo_oe)
);

// File: tb/sclk_sleep_ctrl_bench.sv
module sclk_sleep_ctrl_bench;
  localparam int N = 40;
  localparam int W = 6;
  localparam int S = 4;

  logic clk = 1'b0, rst_n = 1'b0, sclk_in = 1'b0, cs_n = 1'b1;
  logic conv_done = 1'b0, sdo_oe_req = 1'b0;
  logic sdo_oe, sleep, core_rst, result_valid;
  logic [2:0] settle_cnt;
  int checks = 0, fails = 0, rst_seen = 0;

  always #2.5 clk = ~clk;

  sclk_sleep_ctrl #(.SLEEP_TICKS(N), .WAKE_TICKS(W), .SETTLE_CONV(S)) u_sclk_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n), .conv_done(conv_done),
    .sdo_oe_req(sdo_oe_req), .sdo_oe(sdo_oe), .sleep(sleep), .core_rst(core_rst),
    .settle_cnt(settle_cnt), .result_valid(result_valid));

  always @(negedge clk) if (rst_n && core_rst) rst_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic seg(logic lvl, int len);
    sclk_in = lvl;
    repeat (len) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic conv(int n);
    for (int i = 0; i < n; i++) begin
      conv_done = 1'b1;
      @(posedge clk); @(negedge clk);
      conv_done = 1'b0;
    end
  endtask

  function automatic logic next_mode(logic asleep, logic lvl, int len);
    if (!asleep && lvl && len >= N + 2) return 1'b1;
    if (asleep && !lvl && len >= W + 2) return 1'b0;
    return asleep;
  endfunction

  function automatic bit ambiguous(logic lvl, int len);
    return lvl ? (len == N || len == N + 1) : (len == W || len == W + 1);
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic exp_sleep;
    int exp_wakes, base;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sleep", sleep, 0);
    chk("R1 core_rst", core_rst, 0);
    chk("R1 settle_cnt", settle_cnt, 0);
    chk("R1 result_valid", result_valid, 0);

    conv(2);
    chk("R6 count two", settle_cnt, 2);

    // R3: highs one tick short of threshold, split by single lows
    for (int i = 0; i < 4; i++) begin seg(1, N - 1); seg(0, 1); end
    seg(0, 4);
    chk("R3 short highs no sleep", sleep, 0);

    // R2 and R9: exact entry edge while cs toggles
    sclk_in = 1'b1;
    for (int i = 0; i < N + 1; i++) begin cs_n = i[0]; @(posedge clk); @(negedge clk); end
    chk("R2 one edge early", sleep, 0);
    seg(1, 1);
    chk("R2 entered", sleep, 1);
    chk("R9 cs toggles ignored", sleep, 1);
    cs_n = 1'b0; sdo_oe_req = 1'b1; #1;
    chk("R8 oe gated in sleep", sdo_oe, 0);

    conv(3);
    chk("R7 conv ignored in sleep", settle_cnt, 2);

    // R4: low runs restart on a high sample
    seg(0, W - 1); seg(1, 1); seg(0, W - 1); seg(1, 3);
    chk("R4 restart keeps sleep", sleep, 1);

    base = rst_seen;
    seg(0, W + 1);
    chk("R4 one edge early", sleep, 1);
    chk("R5 no pulse yet", core_rst, 0);
    seg(0, 1);
    chk("R4 woke", sleep, 0);
    chk("R5 pulse", core_rst, 1);
    chk("R7 cleared on wake", settle_cnt, 0);
    conv_done = 1'b1;
    seg(0, 1);
    conv_done = 1'b0;
    chk("R5 pulse one cycle", core_rst, 0);
    chk("R5 pulse count", rst_seen - base, 1);
    chk("R7 conv ignored in reset cycle", settle_cnt, 0);
    chk("R8 oe enabled awake", sdo_oe, 1);

    conv(3);
    chk("R6 three unsettled", settle_cnt, 3);
    chk("R6 not valid", result_valid, 0);
    conv(1);
    chk("R6 fourth valid", result_valid, 1);
    conv(2);
    chk("R6 saturates", settle_cnt, S);

    // random segments alternating level
    exp_sleep = 1'b0; exp_wakes = 0; base = rst_seen;
    for (int i = 0; i < 300; i++) begin
      logic lvl, nxt;
      int len;
      lvl = i[0] ? 1'b0 : 1'b1;
      do len = 1 + int'($urandom_range(N + 12)); while (ambiguous(lvl, len));
      cs_n = $urandom_range(1);
      sdo_oe_req = $urandom_range(1);
      seg(lvl, len);
      nxt = next_mode(exp_sleep, lvl, len);
      if (exp_sleep && !nxt) exp_wakes++;
      exp_sleep = nxt;
      chk(lvl ? "R2 random segment" : "R4 random segment", sleep, exp_sleep);
      chk("R8 random oe", sdo_oe, int'(sdo_oe_req && !cs_n && !exp_sleep));
    end
    chk("R5 random wake pulses", rst_seen - base, exp_wakes);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule